// File: doc/BRIEF.md
# Flash Block Verify Sequencer

This block runs an internal margin-verify pass over one block of on-chip flash on behalf of software. Software first programs a small register set: a command code, a block pointer, a byte-offset pointer, a block compare register and an end-offset register. It then clears the two status flags, optionally kicks the watchdog through a keyed write, and raises a start strobe. The strobe stands for the processor entering its halt state.

Once started, the sequencer checks the request for consistency and then reads one flash cell per clock through a synchronous read port. The port returns a margin-fail flag one cycle after each read. Any failing cell raises a sticky verify-error flag. A malformed request raises a sticky access-error flag and reads nothing. Either way, the sequencer ends with a one-cycle wake pulse that lets the processor resume.

Command 01h verifies all 256 offsets of the selected block, whatever the offset registers hold. Command 02h verifies from the offset pointer up to and including the end offset. While the sequencer is busy the register set is frozen.

Top module: `fvs_verify_seq`

## Requirements
- R1: After reset, every register reads 00h, and busy, halt_wake, wdt_restart, mem_rd_en, err_verify and err_access are all low.
- R2: The register map is: address 0 command, 1 block pointer, 2 offset pointer, 3 block compare, 4 end offset, 5 status (bit 1 verify error, bit 2 access error), 6 watchdog key (reads 00h), 7 reads 00h. A write at an idle cycle takes effect at that clock edge. reg_rdata shows the register selected by reg_addr one clock later.
- R3: With command 01h and a valid request, the block issues exactly 256 reads at mem_addr = {block, offset}, with offsets 00h to FFh in ascending order. The offset pointer and end-offset register values are ignored.
- R4: With command 02h and a valid request, the block issues one read per cycle for every offset from the offset pointer to the end offset inclusive, ascending and without gaps.
- R5: If mem_fail is high in the cycle after any read of the run, err_verify is set. The scan still covers the whole range, including a failure on the final offset.
- R6: A command other than 01h or 02h, a block pointer that differs from the block compare register, or (for command 02h) an offset pointer greater than the end offset sets err_access and issues no read.
- R7: busy is high from the clock edge that samples start until halt_wake rises; halt_wake is a single-cycle pulse. For a run of N reads, halt_wake rises N+1 clock edges after the edge that samples start (1 edge for a rejected request). In that same cycle busy is low.
- R8: Register writes and start strobes that arrive while busy is high have no effect.
- R9: A status write at address 5 loads err_verify from data bit 1 and err_access from data bit 2. Otherwise both flags are sticky across runs.
- R10: An idle write of ACh to address 6 produces exactly one single-cycle wdt_restart pulse on the next cycle. Any other value written there produces no pulse.
- R11: After a valid run the offset pointer reads the last offset checked (FFh for command 01h). After a rejected run it keeps its programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| start | input | 1 | Halt-entry strobe that launches the verify pass |
| busy | output | 1 | Verify pass in progress |
| halt_wake | output | 1 | One-cycle pulse ending the pass |
| wdt_restart | output | 1 | One-cycle watchdog clear-and-restart pulse |
| mem_rd_en | output | 1 | Flash read request |
| mem_addr | output | 16 | Flash read address {block, offset} |
| mem_fail | input | 1 | Margin-fail flag for the read issued one cycle earlier |
| err_verify | output | 1 | Sticky verify-error flag (status bit 1) |
| err_access | output | 1 | Sticky access-error flag (status bit 2) |

## Verification
Several properties are checked on every cycle. Reads only happen while busy. Consecutive reads step the address by one, and the block part of the address holds still during a run. The wake pulse lasts one cycle and coincides with busy falling. Each error flag rises only after a failing read, a start, or a status write. A watchdog pulse follows only a keyed idle write. The bench scenarios are needed for the rest: the exact read count and latency per mode, rejection of malformed requests, writes and strobes ignored mid-run, flag stickiness across runs, and the final pointer value.

// File: rtl/fvs_pkg.sv
package fvs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } fvs_state_e;

  localparam int unsigned A_CMD  = 0;
  localparam int unsigned A_BLK  = 1;
  localparam int unsigned A_OFS  = 2;
  localparam int unsigned A_BCMP = 3;
  localparam int unsigned A_OEND = 4;
  localparam int unsigned A_STAT = 5;
  localparam int unsigned A_WDT  = 6;

  localparam int unsigned CMD_WHOLE = 8'h01;
  localparam int unsigned CMD_RANGE = 8'h02;
  localparam int unsigned WDT_KEY   = 8'hAC;

  localparam int unsigned BIT_VFY = 1;
  localparam int unsigned BIT_ACC = 2;

endpackage

// File: rtl/fvs_regs.sv
module fvs_regs
  import fvs_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned BLK_W = 8,
  parameter int unsigned OFS_W = 8,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             busy,
  input  logic             ofs_load,
  input  logic             ofs_inc,
  input  logic             set_vfy,
  input  logic             set_acc,
  output logic [DW-1:0]    cmd,
  output logic [BLK_W-1:0] blk,
  output logic [BLK_W-1:0] blk_cmp,
  output logic [OFS_W-1:0] ofs,
  output logic [OFS_W-1:0] ofs_end,
  output logic             err_vfy,
  output logic             err_acc,
  output logic [DW-1:0]    rdata,
  output logic             wdt_kick
);

  logic          wr_ok;
  logic [DW-1:0] rd_mux;

  assign wr_ok = we && !busy;

  always_comb begin
    rd_mux = '0;
    case (addr)
      AW'(A_CMD):  rd_mux = cmd;
      AW'(A_BLK):  rd_mux = DW'(blk);
      AW'(A_OFS):  rd_mux = DW'(ofs);
      AW'(A_BCMP): rd_mux = DW'(blk_cmp);
      AW'(A_OEND): rd_mux = DW'(ofs_end);
      AW'(A_STAT): begin
        rd_mux[BIT_VFY] = err_vfy;
        rd_mux[BIT_ACC] = err_acc;
      end
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd      <= '0;
      blk      <= '0;
      blk_cmp  <= '0;
      ofs      <= '0;
      ofs_end  <= '0;
      err_vfy  <= 1'b0;
      err_acc  <= 1'b0;
      rdata    <= '0;
      wdt_kick <= 1'b0;
    end else begin
      rdata    <= rd_mux;
      wdt_kick <= wr_ok && (addr == AW'(A_WDT)) && (wdata == DW'(WDT_KEY));
      if (wr_ok) begin
        case (addr)
          AW'(A_CMD):  cmd     <= wdata;
          AW'(A_BLK):  blk     <= wdata[BLK_W-1:0];
          AW'(A_OFS):  ofs     <= wdata[OFS_W-1:0];
          AW'(A_BCMP): blk_cmp <= wdata[BLK_W-1:0];
          AW'(A_OEND): ofs_end <= wdata[OFS_W-1:0];
          AW'(A_STAT): begin
            err_vfy <= wdata[BIT_VFY];
            err_acc <= wdata[BIT_ACC];
          end
          default: ;
        endcase
      end
      if (ofs_load)     ofs <= '0;
      else if (ofs_inc) ofs <= ofs + 1'b1;
      if (set_vfy) err_vfy <= 1'b1;
      if (set_acc) err_acc <= 1'b1;
    end
  end

endmodule

// File: rtl/fvs_range_check.sv
module fvs_range_check
  import fvs_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned BLK_W = 8,
  parameter int unsigned OFS_W = 8
) (
  input  logic [DW-1:0]    cmd,
  input  logic [BLK_W-1:0] blk,
  input  logic [BLK_W-1:0] blk_cmp,
  input  logic [OFS_W-1:0] ofs,
  input  logic [OFS_W-1:0] ofs_end,
  output logic             whole,
  output logic             bad,
  output logic [OFS_W-1:0] eff_end
);

  logic ranged;

  always_comb begin
    whole   = (cmd == DW'(CMD_WHOLE));
    ranged  = (cmd == DW'(CMD_RANGE));
    bad     = !(whole || ranged) || (blk != blk_cmp) || (ranged && (ofs > ofs_end));
    eff_end = whole ? '1 : ofs_end;
  end

endmodule

// File: rtl/fvs_ctrl.sv
module fvs_ctrl
  import fvs_pkg::*;
#(
  parameter int unsigned OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             whole,
  input  logic             bad,
  input  logic [OFS_W-1:0] ofs,
  input  logic [OFS_W-1:0] eff_end,
  input  logic             mem_fail,
  output logic             busy,
  output logic             wake,
  output logic             rd_en,
  output logic             ofs_load,
  output logic             ofs_inc,
  output logic             set_vfy,
  output logic             set_acc
);

  fvs_state_e state;
  logic       rd_pend;
  logic       launch;
  logic       at_end;

  always_comb begin
    launch   = (state == ST_IDLE) && start;
    at_end   = (ofs == eff_end);
    busy     = (state != ST_IDLE);
    rd_en    = (state == ST_SCAN);
    ofs_load = launch && !bad && whole;
    ofs_inc  = rd_en && !at_end;
    set_acc  = launch && bad;
    set_vfy  = rd_pend && mem_fail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      rd_pend <= 1'b0;
      wake    <= 1'b0;
    end else begin
      rd_pend <= rd_en;
      wake    <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= bad ? ST_FIN : ST_SCAN;
        ST_SCAN: if (at_end) state <= ST_FIN;
        ST_FIN: begin
          state <= ST_IDLE;
          wake  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fvs_verify_seq.sv
module fvs_verify_seq
  import fvs_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned BLK_W = 8,
  parameter int unsigned OFS_W = 8,
  parameter int unsigned AW    = 3,
  localparam int unsigned MAW  = BLK_W + OFS_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           start,
  output logic           busy,
  output logic           halt_wake,
  output logic           wdt_restart,
  output logic           mem_rd_en,
  output logic [MAW-1:0] mem_addr,
  input  logic           mem_fail,
  output logic           err_verify,
  output logic           err_access
);

  logic [DW-1:0]    cmd;
  logic [BLK_W-1:0] blk;
  logic [BLK_W-1:0] blk_cmp;
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] ofs_end;
  logic [OFS_W-1:0] eff_end;
  logic             whole;
  logic             bad;
  logic             ofs_load;
  logic             ofs_inc;
  logic             set_vfy;
  logic             set_acc;

  fvs_regs #(.DW(DW), .BLK_W(BLK_W), .OFS_W(OFS_W), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .ofs_load (ofs_load),
    .ofs_inc  (ofs_inc),
    .set_vfy  (set_vfy),
    .set_acc  (set_acc),
    .cmd      (cmd),
    .blk      (blk),
    .blk_cmp  (blk_cmp),
    .ofs      (ofs),
    .ofs_end  (ofs_end),
    .err_vfy  (err_verify),
    .err_acc  (err_access),
    .rdata    (reg_rdata),
    .wdt_kick (wdt_restart)
  );

  fvs_range_check #(.DW(DW), .BLK_W(BLK_W), .OFS_W(OFS_W)) u_check (
    .cmd     (cmd),
    .blk     (blk),
    .blk_cmp (blk_cmp),
    .ofs     (ofs),
    .ofs_end (ofs_end),
    .whole   (whole),
    .bad     (bad),
    .eff_end (eff_end)
  );

  fvs_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .whole    (whole),
    .bad      (bad),
    .ofs      (ofs),
    .eff_end  (eff_end),
    .mem_fail (mem_fail),
    .busy     (busy),
    .wake     (halt_wake),
    .rd_en    (mem_rd_en),
    .ofs_load (ofs_load),
    .ofs_inc  (ofs_inc),
    .set_vfy  (set_vfy),
    .set_acc  (set_acc)
  );

  assign mem_addr = {blk, ofs};

endmodule

// File: rtl/fvs_verify_seq_chk.sv
module fvs_verify_seq_chk
  import fvs_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned BLK_W = 8,
  parameter int unsigned OFS_W = 8,
  parameter int unsigned AW    = 3,
  localparam int unsigned MAW  = BLK_W + OFS_W
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_we,
  input logic [AW-1:0]  reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic           start,
  input logic           busy,
  input logic           halt_wake,
  input logic           wdt_restart,
  input logic           mem_rd_en,
  input logic [MAW-1:0] mem_addr,
  input logic           mem_fail,
  input logic           err_verify,
  input logic           err_access
);

  assert_wake_single_R7: assert property (@(posedge clk) disable iff (rst)
    halt_wake |=> !halt_wake);

  assert_wake_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> halt_wake);

  assert_wake_idle_R7: assert property (@(posedge clk) disable iff (rst)
    halt_wake |-> !busy);

  assert_read_in_run_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);

  assert_read_ascend_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  assert_block_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mem_addr[MAW-1:OFS_W]));

  assert_vfy_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(err_verify) |-> ($past(mem_fail) ||
                           $past(reg_we && reg_addr == AW'(A_STAT) && reg_wdata[BIT_VFY])));

  assert_acc_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_access) |-> ($past(start) ||
                           $past(reg_we && reg_addr == AW'(A_STAT) && reg_wdata[BIT_ACC])));

  assert_vfy_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(err_verify) |-> $past(reg_we && !busy && reg_addr == AW'(A_STAT)));

  assert_wdt_keyed_R10: assert property (@(posedge clk) disable iff (rst)
    wdt_restart |-> $past(reg_we && !busy && reg_addr == AW'(A_WDT) && reg_wdata == DW'(WDT_KEY)));

  assert_wdt_single_R10: assert property (@(posedge clk) disable iff (rst)
    wdt_restart |=> !wdt_restart);

endmodule

bind fvs_verify_seq fvs_verify_seq_chk #(
  .DW(DW), .BLK_W(BLK_W), .OFS_W(OFS_W), .AW(AW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .start       (start),
  .busy        (busy),
  .halt_wake   (halt_wake),
  .wdt_restart (wdt_restart),
  .mem_rd_en   (mem_rd_en),
  .mem_addr    (mem_addr),
  .mem_fail    (mem_fail),
  .err_verify  (err_verify),
  .err_access  (err_access)
);

// File: tb/fvs_verify_seq_tb.sv
module fvs_verify_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        start = 1'b0;
  logic        busy;
  logic        halt_wake;
  logic        wdt_restart;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic        mem_fail = 1'b0;
  logic        err_verify;
  logic        err_access;

  int checks = 0;
  int fails  = 0;
  int total_cyc = 0;
  int rd_cnt = 0;
  int seq_err = 0;
  int wdt_cnt = 0;
  logic [15:0] exp_addr = '0;
  int fail_kind = 0;
  int fail_seed = 0;
  int fail_at_addr = 0;
  bit prev_vfy = 0;
  bit prev_acc = 0;

  always #5 clk = ~clk;

  fvs_verify_seq u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start), .busy(busy),
    .halt_wake(halt_wake), .wdt_restart(wdt_restart), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_fail(mem_fail), .err_verify(err_verify),
    .err_access(err_access)
  );

  function automatic bit cell_fails(int a);
    if (fail_kind == 1) return ((a * 7 + fail_seed) % 53) == 0;
    if (fail_kind == 2) return a == fail_at_addr;
    return 1'b0;
  endfunction

  always @(posedge clk) mem_fail <= mem_rd_en && cell_fails(int'(mem_addr));

  always @(negedge clk) begin
    if (mem_rd_en) begin
      rd_cnt++;
      if (mem_addr != exp_addr) seq_err++;
      exp_addr = exp_addr + 16'd1;
    end
    if (wdt_restart) wdt_cnt++;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(negedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", total_cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run(logic [7:0] cmd, logic [7:0] blk, logic [7:0] bcmp,
                     logic [7:0] ofs, logic [7:0] oend, bit clr, bit inject);
    bit whole, ranged, bad, exp_vfy, exp_acc, got;
    int s, e, n, cyc, busy_bad;
    logic [7:0] d;
    wr(3'd0, cmd); wr(3'd1, blk); wr(3'd2, ofs); wr(3'd3, bcmp); wr(3'd4, oend);
    if (clr) begin
      wr(3'd5, 8'h00);
      prev_vfy = 0; prev_acc = 0;
    end
    wr(3'd6, 8'hAC);
    whole  = (cmd == 8'h01);
    ranged = (cmd == 8'h02);
    bad    = !(whole || ranged) || (blk != bcmp) || (ranged && ofs > oend);
    s = whole ? 0 : int'(ofs);
    e = whole ? 255 : int'(oend);
    n = bad ? 0 : e - s + 1;
    exp_vfy = prev_vfy;
    if (!bad) for (int i = s; i <= e; i++) if (cell_fails({blk, 8'(i)})) exp_vfy = 1;
    exp_acc = prev_acc || bad;
    if (n < 6) inject = 0;
    exp_addr = {blk, 8'(s)}; rd_cnt = 0; seq_err = 0;
    @(negedge clk);
    start = 1'b1;
    cyc = 0; got = 0; busy_bad = 0;
    while (!got && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) start = 1'b0;
      if (inject && cyc == 3) begin
        reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = ~oend;
      end
      if (inject && cyc == 4) begin
        reg_we = 1'b0; start = 1'b1;
      end
      if (inject && cyc == 5) start = 1'b0;
      if (halt_wake) begin
        got = 1;
        chk(!busy, "R7", "busy at wake", busy, 0);
      end else if (!busy) busy_bad++;
    end
    chk(got && cyc == n + 2, "R7", "wake latency", cyc, n + 2);
    chk(busy_bad == 0, "R7", "busy gaps", busy_bad, 0);
    chk(rd_cnt == n, whole ? "R3" : (bad ? "R6" : "R4"), "read count", rd_cnt, n);
    chk(seq_err == 0, whole ? "R3" : "R4", "address order errors", seq_err, 0);
    chk(err_verify == exp_vfy, "R5", "err_verify", err_verify, exp_vfy);
    chk(err_access == exp_acc, "R6", "err_access", err_access, exp_acc);
    @(negedge clk);
    chk(!halt_wake, "R7", "wake width", halt_wake, 0);
    repeat (3) @(negedge clk);
    chk(rd_cnt == n, "R8", "reads after wake", rd_cnt, n);
    rd(3'd2, d);
    chk(d == (bad ? ofs : 8'(e)), "R11", "final offset", d, bad ? ofs : 8'(e));
    if (inject) begin
      rd(3'd4, d);
      chk(d == oend, "R8", "end offset after busy write", d, oend);
    end
    prev_vfy = exp_vfy; prev_acc = exp_acc;
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!busy && !halt_wake && !wdt_restart && !mem_rd_en, "R1", "control outputs",
        {busy, halt_wake, wdt_restart, mem_rd_en}, 0);
    chk(!err_verify && !err_access, "R1", "error flags", {err_verify, err_access}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk(d == 8'h00, "R1", "register after reset", d, 0);
    end
    // R2 register map
    wr(3'd0, 8'h5A); wr(3'd1, 8'h21); wr(3'd2, 8'h33); wr(3'd3, 8'h44); wr(3'd4, 8'h9C);
    rd(3'd0, d); chk(d == 8'h5A, "R2", "command readback", d, 8'h5A);
    rd(3'd1, d); chk(d == 8'h21, "R2", "block readback", d, 8'h21);
    rd(3'd2, d); chk(d == 8'h33, "R2", "offset readback", d, 8'h33);
    rd(3'd3, d); chk(d == 8'h44, "R2", "compare readback", d, 8'h44);
    rd(3'd4, d); chk(d == 8'h9C, "R2", "end readback", d, 8'h9C);
    // R9 status write
    wr(3'd5, 8'hFF);
    rd(3'd5, d); chk(d == 8'h06, "R9", "status readback", d, 8'h06);
    chk(err_verify && err_access, "R9", "flags set by write", {err_verify, err_access}, 3);
    wr(3'd5, 8'h00);
    chk(!err_verify && !err_access, "R9", "flags cleared", {err_verify, err_access}, 0);
    // R10 watchdog key
    wdt_cnt = 0;
    wr(3'd6, 8'hAC); repeat (2) @(negedge clk);
    chk(wdt_cnt == 1, "R10", "pulses for key", wdt_cnt, 1);
    wr(3'd6, 8'h55); repeat (2) @(negedge clk);
    chk(wdt_cnt == 1, "R10", "pulses for wrong key", wdt_cnt, 1);
    rd(3'd6, d); chk(d == 8'h00, "R2", "watchdog reads zero", d, 0);
    // directed runs
    fail_kind = 0;
    run(8'h01, 8'h3C, 8'h3C, 8'h40, 8'h10, 1, 1);   // R3 whole block ignores offsets
    fail_kind = 2; fail_at_addr = 16'h121F;
    run(8'h02, 8'h12, 8'h12, 8'h10, 8'h1F, 1, 1);   // R5 fail on final offset
    fail_kind = 0;
    run(8'h02, 8'h12, 8'h12, 8'h00, 8'h05, 0, 0);   // R9 sticky verify flag
    run(8'h02, 8'h07, 8'h07, 8'h80, 8'h80, 1, 0);   // R4 single offset
    run(8'h02, 8'h07, 8'h07, 8'h81, 8'h80, 1, 0);   // R6 start beyond end
    run(8'h01, 8'h07, 8'h08, 8'h00, 8'hFF, 1, 0);   // R6 block mismatch
    run(8'h03, 8'h07, 8'h07, 8'h00, 8'h0F, 1, 0);   // R6 unknown command
    fail_kind = 2; fail_at_addr = 16'h4400;
    run(8'h02, 8'h44, 8'h44, 8'h00, 8'hFF, 1, 1);   // R4 full range, fail on first
    // random runs
    for (int k = 0; k < 40; k++) begin
      logic [7:0] c, b, bc, o, oe, t;
      int pick;
      pick = int'($urandom_range(0, 99));
      c = (pick < 10) ? 8'h01 : (pick < 85) ? 8'h02 : 8'($urandom_range(3, 255));
      b = 8'($urandom);
      bc = ($urandom_range(0, 9) == 0) ? ~b : b;
      o = 8'($urandom); oe = 8'($urandom);
      if (o > oe && $urandom_range(0, 9) != 0) begin t = o; o = oe; oe = t; end
      fail_kind = int'($urandom_range(0, 1));
      fail_seed = int'($urandom_range(0, 52));
      run(c, b, bc, o, oe, 1, $urandom_range(0, 3) == 0);
    end
    summary();
    $finish;
  end

endmodule